// File: doc/BRIEF.md
# Spectral Support Change Detector

This block decides whether the spectral support of a signal has moved. It does this by correlating a fixed row of coefficients against a group of twelve incoming sample words. Software or a neighbouring solver writes the coefficient row through an addressed write port. Samples then stream in, one word per clock while a valid strobe is high. Each accepted sample is multiplied by the coefficient at its position in the window, and the products are accumulated.

When the twelfth valid sample of a window has been taken, the block squares the accumulated sum into an energy figure. It compares that figure with an unsigned threshold. If the energy is strictly greater, the block raises a change flag for one clock. The accumulator and the position counter then restart for the next window.

All data words are 18-bit two's complement. The usual interpretation has 12 fraction bits. The arithmetic is exact integer arithmetic, so the binary point only scales the threshold. The accumulator is 4 bits wider than a full product, so it cannot wrap.

Top module: `scd_change_detector`

## Requirements
- R1: A synchronous reset holds the change flag low and clears the window position and the accumulator. Samples accepted before a reset never count toward a window completed after it.
- R2: A window is exactly 12 valid samples. The change flag can rise only in the clock after the edge that accepts the 12th sample, and never after fewer samples.
- R3: The window sum is exact for all inputs. With every coefficient and every sample at -131072, the energy is (12·2^34)^2, and a threshold one below that value yields a flag.
- R4: The energy is the square of the signed window sum, so negating every sample gives the same decision.
- R5: The comparison is strict. An energy equal to the threshold gives no flag, and a threshold one lower gives a flag.
- R6: A detection drives the change flag high for exactly one clock.
- R7: Clocks with the valid strobe low neither advance the window position nor change the accumulator.
- R8: Coefficients at addresses 0 to 11 are held until rewritten. Writes to addresses 12 to 15 are ignored. A sample accepted in the same clock as a write to its own coefficient uses the old coefficient.
- R9: After a window completes, the next window starts from a zero sum at position 0, so back-to-back windows are judged independently.
- R10: The threshold is sampled at the edge that accepts the 12th sample. Changing it one clock later does not alter that window's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 4 | Coefficient position; 0 to 11 are valid |
| coef_data | input | 18 | Signed coefficient value |
| smp_valid | input | 1 | Sample strobe; one sample per clock while high |
| smp_data | input | 18 | Signed sample value |
| threshold | input | 80 | Unsigned energy threshold |
| change_o | output | 1 | One-clock support change flag |

## Verification
The assertions assume that the coefficient row is written in full before the first window whose result matters. This is because the bank has no reset. They also assume that reset is applied for at least one clock at start-up. The stimulus loads all twelve coefficients while reset is still high. It only changes coefficients between windows, or on purpose in the same clock as a sample. The threshold changes only on clocks where no window ends, except in the single test of R10. The sample and coefficient values include the most negative code, so the bound assertion on the running sum is exercised at its edge.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int unsigned SCD_DATA_W  = 18;
  localparam int unsigned SCD_TAPS    = 12;
  localparam int unsigned SCD_GUARD_W = 4;
endpackage

// File: rtl/scd_coef_bank.sv
module scd_coef_bank #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned TAPS   = 12,
  localparam int unsigned ADDR_W = $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic signed [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0]        raddr,
  output logic signed [DATA_W-1:0] rdata
);
  logic [TAPS-1:0][DATA_W-1:0] bank;
  logic                        wr_hit;

  assign wr_hit = we && (int'(waddr) < int'(TAPS));

  for (genvar g = 0; g < TAPS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_hit && (int'(waddr) == g)) bank[g] <= wdata;
    end
  end

  assign rdata = $signed(bank[raddr]);

  assert_hold_R8: assert property (@(posedge clk) !wr_hit |=> $stable(bank))
    else $error("coefficient bank changed without a valid write");
endmodule

// File: rtl/scd_accum.sv
module scd_accum #(
  parameter int unsigned DATA_W  = 18,
  parameter int unsigned TAPS    = 12,
  parameter int unsigned GUARD_W = 4,
  localparam int unsigned PROD_W = 2 * DATA_W,
  localparam int unsigned SUM_W  = PROD_W + GUARD_W,
  localparam int unsigned CNT_W  = $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [DATA_W-1:0] coef,
  output logic [CNT_W-1:0]         pos_o,
  output logic                     last_o,
  output logic signed [SUM_W-1:0]  win_sum_o
);
  localparam logic signed [SUM_W-1:0] BOUND = SUM_W'(TAPS) <<< (PROD_W - 2);

  function automatic logic signed [SUM_W-1:0] tap_product(
    input logic signed [DATA_W-1:0] a,
    input logic signed [DATA_W-1:0] b);
    logic signed [PROD_W-1:0] p;
    p = a * b;
    return {{GUARD_W{p[PROD_W-1]}}, p};
  endfunction

  logic [CNT_W-1:0]        pos_q;
  logic signed [SUM_W-1:0] acc_q;
  logic signed [SUM_W-1:0] next_sum;

  assign next_sum  = acc_q + tap_product(sample, coef);
  assign last_o    = valid && (pos_q == CNT_W'(TAPS - 1));
  assign win_sum_o = next_sum;
  assign pos_o     = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      acc_q <= '0;
    end else if (last_o) begin
      pos_q <= '0;
      acc_q <= '0;
    end else if (valid) begin
      pos_q <= pos_q + 1'b1;
      acc_q <= next_sum;
    end
  end

  assert_pos_range_R2: assert property (@(posedge clk) disable iff (rst)
    int'(pos_q) < int'(TAPS))
    else $error("window position out of range");
  assert_acc_clear_R9: assert property (@(posedge clk) disable iff (rst)
    last_o |=> (acc_q == '0) && (pos_q == '0))
    else $error("accumulator not cleared after window");
  assert_gap_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(acc_q) && $stable(pos_q))
    else $error("state moved on an idle clock");
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    valid |-> (win_sum_o <= BOUND) && (win_sum_o >= -BOUND))
    else $error("window sum outside its bound");
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && (pos_q == '0))
    else $error("reset did not clear the window");
endmodule

// File: rtl/scd_energy_cmp.sv
module scd_energy_cmp #(
  parameter int unsigned SUM_W = 40,
  localparam int unsigned ENERGY_W = 2 * SUM_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fire,
  input  logic signed [SUM_W-1:0]  sum,
  input  logic [ENERGY_W-1:0]      thr,
  output logic                     hit_o
);
  function automatic logic [ENERGY_W-1:0] energy_of(input logic signed [SUM_W-1:0] s);
    logic signed [ENERGY_W-1:0] w;
    w = {{SUM_W{s[SUM_W-1]}}, s};
    return ENERGY_W'(w * w);
  endfunction

  logic [ENERGY_W-1:0] energy;
  logic                hit_q;

  assign energy = energy_of(sum);

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= fire && (energy > thr);
  end

  assign hit_o = hit_q;

  assert_fire_needed_R2: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !hit_q)
    else $error("flag raised without a completed window");
endmodule

// File: rtl/scd_change_detector.sv
module scd_change_detector
  import scd_pkg::*;
#(
  parameter int unsigned DATA_W  = SCD_DATA_W,
  parameter int unsigned TAPS    = SCD_TAPS,
  parameter int unsigned GUARD_W = SCD_GUARD_W,
  localparam int unsigned ADDR_W   = $clog2(TAPS),
  localparam int unsigned SUM_W    = 2 * DATA_W + GUARD_W,
  localparam int unsigned ENERGY_W = 2 * SUM_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     coef_we,
  input  logic [ADDR_W-1:0]        coef_addr,
  input  logic signed [DATA_W-1:0] coef_data,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_data,
  input  logic [ENERGY_W-1:0]      threshold,
  output logic                     change_o
);
  logic [ADDR_W-1:0]        win_pos;
  logic signed [DATA_W-1:0] tap_coef;
  logic                     win_last;
  logic signed [SUM_W-1:0]  win_sum;

  scd_coef_bank #(.DATA_W(DATA_W), .TAPS(TAPS)) u_bank (
    .clk(clk), .we(coef_we), .waddr(coef_addr), .wdata(coef_data),
    .raddr(win_pos), .rdata(tap_coef));

  scd_accum #(.DATA_W(DATA_W), .TAPS(TAPS), .GUARD_W(GUARD_W)) u_accum (
    .clk(clk), .rst(rst), .valid(smp_valid), .sample(smp_data), .coef(tap_coef),
    .pos_o(win_pos), .last_o(win_last), .win_sum_o(win_sum));

  scd_energy_cmp #(.SUM_W(SUM_W)) u_cmp (
    .clk(clk), .rst(rst), .fire(win_last), .sum(win_sum), .thr(threshold),
    .hit_o(change_o));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    change_o |=> !change_o)
    else $error("change flag longer than one clock");
  assert_pulse_cause_R2: assert property (@(posedge clk) disable iff (rst)
    change_o |-> $past(win_last))
    else $error("change flag not preceded by a window end");
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !change_o)
    else $error("change flag high after reset");
endmodule

// File: tb/test_scd_change_detector.sv
module test_scd_change_detector;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               coef_we = 1'b0;
  logic [3:0]         coef_addr = '0;
  logic signed [17:0] coef_data = '0;
  logic               smp_valid = 1'b0;
  logic signed [17:0] smp_data = '0;
  logic [79:0]        threshold = '0;
  logic               change_o;

  scd_change_detector i_scd_change_detector (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .smp_valid(smp_valid), .smp_data(smp_data),
    .threshold(threshold), .change_o(change_o));

  always #10 clk = ~clk;

  int     total = 0;
  int     bad = 0;
  int     pulses = 0;
  int     cycles = 0;
  string  cur_req = "R1";
  longint mc[12];
  int     mpos = 0;
  longint msum = 0;
  bit     mexp = 1'b0;
  longint win[12];

  function automatic logic [79:0] sq(input longint v);
    logic signed [79:0] w;
    w = 80'(v);
    return 80'(w * w);
  endfunction

  function automatic logic [79:0] win_energy();
    longint s = 0;
    for (int i = 0; i < 12; i++) s += mc[i] * win[i];
    return sq(s);
  endfunction

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    longint s;
    if (rst) begin
      mpos = 0; msum = 0; mexp = 1'b0;
    end else begin
      mexp = 1'b0;
      if (smp_valid) begin
        s = msum + mc[mpos] * longint'(smp_data);
        if (mpos == 11) begin
          mexp = sq(s) > threshold;
          msum = 0; mpos = 0;
        end else begin
          msum = s; mpos++;
        end
      end
    end
    if (coef_we && coef_addr < 12) mc[coef_addr] = longint'(coef_data);
  end

  always @(negedge clk) begin
    cycles++;
    total++;
    if (change_o !== mexp) begin
      bad++;
      $display("FAIL %s change_o actual=%0b expected=%0b cycle=%0d", cur_req, change_o, mexp, cycles);
    end
    if (change_o === 1'b1) pulses++;
    if (cycles > 50000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<=50000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check_pulses(input string req, input int expv);
    total++;
    if (pulses != expv) begin
      bad++;
      $display("FAIL %s pulse count actual=%0d expected=%0d", req, pulses, expv);
    end
    pulses = 0;
  endtask

  task automatic wr(input int a, input longint v);
    coef_we = 1'b1; coef_addr = 4'(a); coef_data = 18'(v);
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic push(input longint v);
    smp_valid = 1'b1; smp_data = 18'(v);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic run_window(input int gap);
    for (int i = 0; i < 12; i++) begin
      push(win[i]);
      if (gap > 0 && (i % 3) == 1) repeat (gap) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [79:0] e;
    @(negedge clk);
    // R1: reset state, coefficients loaded while in reset
    for (int i = 0; i < 12; i++) wr(i, 4096 * (i + 1));
    total++;
    if (change_o !== 1'b0) begin
      bad++; $display("FAIL R1 reset change_o actual=%0b expected=0", change_o);
    end
    rst = 1'b0;
    for (int i = 0; i < 12; i++) win[i] = 4096 - i * 500;
    threshold = '0;
    for (int i = 0; i < 5; i++) push(win[i]);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check_pulses("R1", 0);
    run_window(0);
    check_pulses("R1", 1);

    // R2 / R6: one pulse per twelve samples; eleven samples give none
    cur_req = "R2";
    for (int i = 0; i < 11; i++) push(win[i]);
    repeat (3) @(negedge clk);
    check_pulses("R2", 0);
    push(win[11]);
    repeat (3) @(negedge clk);
    check_pulses("R6", 1);

    // R5: strict comparison
    cur_req = "R5";
    for (int i = 0; i < 12; i++) win[i] = (i % 2 == 0) ? 3000 + i : -1000 - 7 * i;
    e = win_energy();
    threshold = e;     run_window(0); check_pulses("R5", 0);
    threshold = e - 1; run_window(0); check_pulses("R5", 1);

    // R4: negated samples give the same energy
    cur_req = "R4";
    for (int i = 0; i < 12; i++) win[i] = -win[i];
    total++;
    if (win_energy() != e) begin
      bad++; $display("FAIL R4 bench energy actual=%0d expected=%0d", win_energy(), e);
    end
    run_window(0); check_pulses("R4", 1);

    // R3: extreme values, no wrap
    cur_req = "R3";
    for (int i = 0; i < 12; i++) wr(i, -131072);
    for (int i = 0; i < 12; i++) win[i] = -131072;
    e = sq(longint'(12) <<< 34);
    threshold = e - 1; run_window(0); check_pulses("R3", 1);
    threshold = e;     run_window(0); check_pulses("R3", 0);

    // R7: idle clocks inside a window
    cur_req = "R7";
    for (int i = 0; i < 12; i++) wr(i, 100 * i - 500);
    for (int i = 0; i < 12; i++) win[i] = 2000 - 300 * i;
    e = win_energy();
    threshold = e - 1; run_window(2); check_pulses("R7", 1);
    threshold = e;     run_window(3); check_pulses("R7", 0);

    // R8: out-of-range writes ignored, same-clock write uses old coefficient
    cur_req = "R8";
    for (int a = 12; a < 16; a++) wr(a, 77777);
    threshold = e - 1; run_window(0); check_pulses("R8", 1);
    threshold = e;     run_window(0); check_pulses("R8", 0);
    threshold = e - 1;
    coef_we = 1'b1; coef_addr = 4'd0; coef_data = 18'sd30000;
    push(win[0]);
    coef_we = 1'b0;
    for (int i = 1; i < 12; i++) push(win[i]);
    repeat (3) @(negedge clk);
    check_pulses("R8", 1);

    // R9 / R10: back-to-back windows, threshold changed one clock late
    cur_req = "R9";
    for (int i = 0; i < 12; i++) wr(i, 1000);
    for (int i = 0; i < 12; i++) win[i] = 1000;
    e = win_energy();
    threshold = e - 1;
    for (int i = 0; i < 12; i++) push(win[i]);
    for (int i = 0; i < 12; i++) push((i == 0) ? 1 : 0);
    repeat (3) @(negedge clk);
    check_pulses("R9", 1);
    cur_req = "R10";
    threshold = e - 1;
    for (int i = 0; i < 12; i++) push(win[i]);
    threshold = e + 5;
    repeat (3) @(negedge clk);
    check_pulses("R10", 1);
    threshold = e;
    for (int i = 0; i < 12; i++) push(win[i]);
    threshold = '0;
    repeat (3) @(negedge clk);
    check_pulses("R10", 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule